// File: doc/BRIEF.md
# Pipelined Converter Redundant-Code Combiner

This block turns the raw digital decisions of a multi-stage pipelined analog-to-digital converter into one corrected output word per sample. Each stage of the converter resolves its own small code, and those codes reach the block in a skewed pattern. The first stage's code for a sample arrives together with a valid strobe. The second stage's code for that same sample arrives one clock later, and so on down to the final stage. The block delays each earlier code just long enough for all codes of one sample to meet. It then adds them with neighbouring stages overlapping by one bit. As a result, a coarse decision that is off by one step is cancelled by the fine code that follows it.

Two build variants are chosen by a parameter. In the multi-bit variant, every stage ahead of the last delivers a binary code of `STAGE_BITS` bits. In the 1.5-bit variant, every such stage delivers the outputs of its two comparators, and the block converts them to a three-level digit. In both variants, the final stage enters the sum at its full width. A run-time input compensates for a half-step offset that the analog front stage may add. The corrected word is clamped to the legal output range, so it never wraps around. A new sample may enter on every clock.

Top module: `adc_correction_combiner`

## Requirements
- R1: While `rst_n` is low, `valid_o` is 0 and `result_o` is 0.
- R2: A sample whose first-stage code is taken with `valid_i` high at clock edge k produces `valid_o` high and its result after edge k+NUM_STAGES-1 (edge k+3 by default). Samples may arrive on consecutive clocks, and each one produces its own result on consecutive clocks. `valid_o` is high at no other time.
- R3: Stage i (0 = first) drives `coarse_codes_i[i*W +: W]`, and each code is taken i cycles after its sample's valid. In the default build (W=4, four stages), the result is c0·256 + c1·32 + c2·4 + f. Each coarse code carries a weight of 2^(W-1) relative to the stage after it, which is one bit of overlap.
- R4: Raising a coarse code by one while lowering the next stage's code by 2^(W-1) (8 by default) leaves the result unchanged.
- R5: The final stage's code `fine_code_i` (LAST_BITS wide, 3 by default) is added at full resolution without any shift. With all coarse codes at 0 and the offset off, the result equals the fine code.
- R6: A sum above 2^N-1 is clamped to 2^N-1. N is (NUM_STAGES-1)·(W-1)+LAST_BITS, which is 12 by default, so the clamp value is 4095.
- R7: When `half_lsb_offset_i` is high, 2^(B1-2) times the second stage's weight is subtracted from the sum. B1 is the second stage's code width. This is 128 by default and 8 in the 1.5-bit build. A negative result is clamped to 0.
- R8: With HALF_BIT=1, each coarse field is 2 bits wide and holds a thermometer code: bit0 is the lower comparator and bit1 is the upper one. The codes map as 00→0, 01→1 and 11→2, and the illegal pattern 10 maps to 1. The result is then d0·16 + d1·8 + d2·4 + f, with N=6.
- R9: On a cycle in which no sample completes, `result_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| valid_i | input | 1 | Marks a new sample whose first-stage code is on field 0 |
| half_lsb_offset_i | input | 1 | Enables subtraction of the front-stage half-step offset |
| coarse_codes_i | input | (NUM_STAGES-1)·W | Codes of all stages ahead of the last, stage i in field i, each skewed by i cycles |
| fine_code_i | input | LAST_BITS | Final-stage code, arriving NUM_STAGES-1 cycles after the sample's valid |
| valid_o | output | 1 | A corrected result is on `result_o` |
| result_o | output | N | Corrected, clamped output word |

## Verification
Every result is due exactly NUM_STAGES-1 clock edges after the edge that took its first-stage code: three edges in the default build and in the 1.5-bit build alike. The driver records that due cycle with each expected value when it queues the value. The monitor samples on falling edges and compares both the value and the cycle in which it appears, so a result that comes early or late fails just as a wrong value does. The driver also holds the skew itself: on each cycle it places every stage's code for the sample launched that many cycles earlier. The offset input is changed only after the pipeline has drained.

// File: rtl/adc_comb_pkg.sv
package adc_comb_pkg;

  // Width of one coarse field: two comparator bits in 1.5-bit mode.
  function automatic int code_width(int half_bit, int stage_bits);
    return (half_bit != 0) ? 2 : stage_bits;
  endfunction

  // Left shift applied to stage idx; the final stage is not shifted.
  function automatic int stage_shift(int idx, int num_stages, int cw, int last_bits);
    if (idx >= num_stages - 1) return 0;
    return (last_bits - 1) + (num_stages - 2 - idx) * (cw - 1);
  endfunction

  // Corrected output resolution.
  function automatic int out_width(int num_stages, int cw, int last_bits);
    return (num_stages - 1) * (cw - 1) + last_bits;
  endfunction

endpackage

// File: rtl/adc_stage_encoder.sv
module adc_stage_encoder #(
  parameter int CODE_W   = 4,
  parameter int HALF_BIT = 0
) (
  input  logic [CODE_W-1:0] raw_i,
  output logic [CODE_W-1:0] code_o
);

  if (HALF_BIT != 0) begin : g_thermo
    // Lower comparator in bit0, upper in bit1.
    always_comb begin
      case (raw_i)
        CODE_W'(0): code_o = CODE_W'(0);
        CODE_W'(1): code_o = CODE_W'(1);
        CODE_W'(3): code_o = CODE_W'(2);
        default:    code_o = CODE_W'(1);
      endcase
    end

    always_comb begin
      assert_thermo_legal_R8: assert (code_o != CODE_W'(3));
    end
  end else begin : g_binary
    always_comb code_o = raw_i;
  end

endmodule

// File: rtl/adc_align_delay.sv
module adc_align_delay #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [DEPTH];
  logic [WIDTH-1:0] stg_d [DEPTH];
  logic             shift_en;

  // Full throughput: the line advances on every clock.
  assign shift_en = 1'b1;

  always_comb begin
    stg_d[0] = d_i;
    for (int j = 1; j < DEPTH; j++) stg_d[j] = stg_q[j-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) stg_q[j] <= '0;
    end else if (shift_en) begin
      for (int j = 0; j < DEPTH; j++) stg_q[j] <= stg_d[j];
    end
  end

  assign q_o = stg_q[DEPTH-1];

  assert_align_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stg_q[0] == $past(d_i));

  for (genvar j = 1; j < DEPTH; j++) begin : g_chk
    assert_align_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> stg_q[j] == $past(stg_q[j-1]));
  end

endmodule

// File: rtl/adc_overlap_adder.sv
module adc_overlap_adder
  import adc_comb_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int CODE_W     = 4,
  parameter int LAST_BITS  = 3,
  parameter int OUT_W      = 12
) (
  input  logic [(NUM_STAGES-1)*CODE_W-1:0] codes_i,
  input  logic [LAST_BITS-1:0]             fine_i,
  input  logic                             offset_en_i,
  output logic [OUT_W-1:0]                 sum_o
);

  localparam int SW     = OUT_W + 3;
  localparam int B1     = (NUM_STAGES > 2) ? CODE_W : LAST_BITS;
  localparam int OFS_SH = (B1 - 2) + stage_shift(1, NUM_STAGES, CODE_W, LAST_BITS);
  localparam logic signed [SW-1:0] OFS_V = SW'(1) << OFS_SH;
  localparam logic signed [SW-1:0] TOP_V = (SW'(1) << OUT_W) - SW'(1);

  logic signed [SW-1:0] acc;

  always_comb begin
    acc = SW'(fine_i);
    for (int i = 0; i < NUM_STAGES - 1; i++) begin
      acc = acc + (SW'(codes_i[i*CODE_W +: CODE_W]) << stage_shift(i, NUM_STAGES, CODE_W, LAST_BITS));
    end
    if (offset_en_i) acc = acc - OFS_V;
    if (acc < 0)          sum_o = '0;
    else if (acc > TOP_V) sum_o = TOP_V[OUT_W-1:0];
    else                  sum_o = acc[OUT_W-1:0];
  end

  // Without the offset every term is non-negative, so the word never
  // falls below the unshifted final-stage code.
  always_comb begin
    if (!offset_en_i) begin
      assert_floor_R5: assert (sum_o >= OUT_W'(fine_i));
    end
  end

endmodule

// File: rtl/adc_correction_combiner.sv
module adc_correction_combiner
  import adc_comb_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int STAGE_BITS = 4,
  parameter int LAST_BITS  = 3,
  parameter int HALF_BIT   = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  input  logic half_lsb_offset_i,
  input  logic [(NUM_STAGES-1)*code_width(HALF_BIT, STAGE_BITS)-1:0] coarse_codes_i,
  input  logic [LAST_BITS-1:0] fine_code_i,
  output logic valid_o,
  output logic [out_width(NUM_STAGES, code_width(HALF_BIT, STAGE_BITS), LAST_BITS)-1:0] result_o
);

  localparam int CW    = code_width(HALF_BIT, STAGE_BITS);
  localparam int OUT_W = out_width(NUM_STAGES, CW, LAST_BITS);

  logic [(NUM_STAGES-1)*CW-1:0] aligned_codes;
  logic                         aligned_valid;
  logic [OUT_W-1:0]             sum_w;
  logic [OUT_W-1:0]             result_d, result_q;
  logic                         valid_d, valid_q;

  for (genvar i = 0; i < NUM_STAGES - 1; i++) begin : g_stage
    logic [CW-1:0] enc_code;
    logic [CW-1:0] algn_code;

    adc_stage_encoder #(
      .CODE_W   (CW),
      .HALF_BIT (HALF_BIT)
    ) u_enc (
      .raw_i  (coarse_codes_i[i*CW +: CW]),
      .code_o (enc_code)
    );

    adc_align_delay #(
      .WIDTH (CW),
      .DEPTH (NUM_STAGES - 1 - i)
    ) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (enc_code),
      .q_o   (algn_code)
    );

    assign aligned_codes[i*CW +: CW] = algn_code;
  end

  adc_align_delay #(
    .WIDTH (1),
    .DEPTH (NUM_STAGES - 1)
  ) u_vld_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (valid_i),
    .q_o   (aligned_valid)
  );

  adc_overlap_adder #(
    .NUM_STAGES (NUM_STAGES),
    .CODE_W     (CW),
    .LAST_BITS  (LAST_BITS),
    .OUT_W      (OUT_W)
  ) u_add (
    .codes_i     (aligned_codes),
    .fine_i      (fine_code_i),
    .offset_en_i (half_lsb_offset_i),
    .sum_o       (sum_w)
  );

  always_comb begin
    result_d = result_q;
    if (aligned_valid) result_d = sum_w;
    valid_d = aligned_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      result_q <= result_d;
      valid_q  <= valid_d;
    end
  end

  assign result_o = result_q;
  assign valid_o  = valid_q;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned_valid |=> $stable(result_o));

endmodule

// File: tb/adc_correction_combiner_tb_top.sv
module adc_correction_combiner_tb_top;

  typedef struct {
    int    exp;
    int    due;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        offset = 1'b0;
  logic [11:0] coarse_m = '0;
  logic [5:0]  coarse_h = '0;
  logic [2:0]  fine = '0;
  logic        vo_m, vo_h;
  logic [11:0] res_m;
  logic [5:0]  res_h;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  item_t q_m[$];
  item_t q_h[$];
  int hist_b[1];
  int hist_c[2];
  int hist_d[3];
  int last_m = 0, last_h = 0;
  bit seen_m = 0, seen_h = 0;

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) cyc <= cyc + 1;

  adc_correction_combiner dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .half_lsb_offset_i(offset),
    .coarse_codes_i(coarse_m), .fine_code_i(fine), .valid_o(vo_m), .result_o(res_m)
  );

  adc_correction_combiner #(.HALF_BIT(1)) dut_h_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .half_lsb_offset_i(offset),
    .coarse_codes_i(coarse_h), .fine_code_i(fine), .valid_o(vo_h), .result_o(res_h)
  );

  function automatic int clampv(int s, int top);
    if (s < 0) return 0;
    if (s > top) return top;
    return s;
  endfunction

  function automatic int exp_main(int a, int b, int c, int d, bit off);
    return clampv(a*256 + b*32 + c*4 + d - (off ? 128 : 0), 4095);
  endfunction

  function automatic int th(int x);
    case (x & 3)
      0: return 0;
      3: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_half(int a, int b, int c, int d, bit off);
    return clampv(th(a)*16 + th(b)*8 + th(c)*4 + d - (off ? 8 : 0), 63);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // One clock of stimulus: launches (a,b,c,d) if v, and drives the skewed
  // later-stage codes of the samples launched 1..3 cycles earlier.
  task automatic step(input bit v, input int a, input int b, input int c, input int d, input string tag);
    item_t it;
    @(negedge clk);
    valid_i  = v;
    coarse_m = {4'(hist_c[1]), 4'(hist_b[0]), 4'(a)};
    coarse_h = {2'(hist_c[1]), 2'(hist_b[0]), 2'(a)};
    fine     = 3'(hist_d[2]);
    hist_d[2] = hist_d[1]; hist_d[1] = hist_d[0]; hist_d[0] = d;
    hist_c[1] = hist_c[0]; hist_c[0] = c;
    hist_b[0] = b;
    if (v) begin
      it.due = cyc + 4;
      it.tag = tag;
      it.exp = exp_main(a, b, c, d, offset);
      q_m.push_back(it);
      it.exp = exp_half(a, b, c, d, offset);
      q_h.push_back(it);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 0, "");
  endtask

  // Scoreboard monitors, sampling on the falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q_m.size() > 0 && q_m[0].due == cyc) begin
        check(vo_m === 1'b1, {q_m[0].tag, " R2 valid"}, int'(vo_m), 1);
        check(res_m == 12'(q_m[0].exp), q_m[0].tag, int'(res_m), q_m[0].exp);
        last_m = int'(res_m); seen_m = 1;
        void'(q_m.pop_front());
      end else if (vo_m) begin
        check(1'b0, "R2 unexpected valid", 1, 0);
      end else if (seen_m) begin
        check(int'(res_m) == last_m, "R9 hold", int'(res_m), last_m);
      end

      if (q_h.size() > 0 && q_h[0].due == cyc) begin
        check(vo_h === 1'b1, {q_h[0].tag, " R2 valid (1.5-bit)"}, int'(vo_h), 1);
        check(res_h == 6'(q_h[0].exp), {q_h[0].tag, " (1.5-bit)"}, int'(res_h), q_h[0].exp);
        last_h = int'(res_h); seen_h = 1;
        void'(q_h.pop_front());
      end else if (vo_h) begin
        check(1'b0, "R2 unexpected valid (1.5-bit)", 1, 0);
      end else if (seen_h) begin
        check(int'(res_h) == last_h, "R9 hold (1.5-bit)", int'(res_h), last_h);
      end
    end
  end

  initial begin
    hist_b = '{default: 0};
    hist_c = '{default: 0};
    hist_d = '{default: 0};
    repeat (3) @(negedge clk);
    check(vo_m == 1'b0, "R1 valid in reset", int'(vo_m), 0);
    check(res_m == 12'd0, "R1 result in reset", int'(res_m), 0);
    check(vo_h == 1'b0, "R1 valid in reset (1.5-bit)", int'(vo_h), 0);
    check(res_h == 6'd0, "R1 result in reset (1.5-bit)", int'(res_h), 0);
    rst_n = 1'b1;
    idle(2);

    step(1, 3, 5, 9, 2, "R3");
    step(1, 10, 1, 14, 6, "R3");
    idle(1);
    step(1, 0, 0, 0, 5, "R5");
    step(1, 0, 0, 0, 7, "R5");
    step(1, 5, 8, 0, 0, "R4 coarse low");
    step(1, 6, 0, 0, 0, "R4 coarse high");
    step(1, 0, 4, 8, 0, "R4 mid low");
    step(1, 0, 5, 0, 0, "R4 mid high");
    step(1, 15, 15, 15, 7, "R6");
    step(1, 15, 15, 0, 0, "R6");
    step(1, 2, 1, 3, 4, "R8");
    step(1, 2, 2, 2, 1, "R8");
    for (int i = 0; i < 6; i++) step(1, i*2, 15 - i, i, i % 8, "R2 burst");
    idle(8);

    @(negedge clk);
    offset = 1'b1;
    step(1, 0, 0, 0, 0, "R7 negative");
    step(1, 1, 0, 0, 0, "R7");
    step(1, 0, 4, 0, 0, "R7");
    step(1, 0, 3, 0, 0, "R7 negative");
    step(1, 3, 0, 0, 3, "R7");
    idle(8);
    @(negedge clk);
    offset = 1'b0;
    idle(2);

    check(q_m.size() == 0 && q_h.size() == 0, "R2 results outstanding",
          q_m.size() + q_h.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule